// File: doc/BRIEF.md
# Receiver Status and Error Reporting

This block sits behind a biphase-mark digital audio receiver. It turns the decoder's per-sample parity and coding-violation pulses, together with the PLL lock indication, into an error flag that holds for one sample period. It also merges that flag with the received validity bit into a second flag. An interpolation stage downstream can use that second flag to conceal bad samples.

It also drives six shared output pins. With the display select high, the pins show channel-status bits for the chosen channel. These are latched once per status block, and the mapping of the upper five pins depends on whether status bit 0 marks a professional or a consumer stream. With the select low, the pins show a frequency-and-error report. The report refreshes three times per status block and stays unqualified until the frequency reference has been present for two thirds of a block.

Top module: `rx_status_report`

## Requirements
- R1: At each `sample_stb`, while locked, `err_flag` becomes 1 if any `par_err` or `bmc_err` pulse occurred since the previous strobe, including the strobe cycle, and 0 otherwise. Between strobes the flag holds while `pll_locked` is 1.
- R2: When `pll_locked` is 0, `err_flag` is 1 on the next clock whether or not a strobe occurs. It stays 1 after relock until a strobe evaluates a clean sample.
- R3: `vflag` equals the `validity` value latched at the last strobe, ORed with `err_flag`.
- R4: With `sel`=1, `pins` shows the latched status field. With `sel`=0, `pins` shows the report, encoded as pins[5:3]=frequency code, pins[2]=unlock seen, pins[1]=biphase error seen and pins[0]=parity error seen.
- R5: The status field is captured only in the clock after a rising edge of `blk_bnd`, from `cs_left` when `chan_sel`=0 and from `cs_right` when `chan_sel`=1. Changes to the inputs at any other time do not alter the captured field.
- R6: The status field has pins[0]=bit 0. If bit 0 is 0 (professional), pins[5:1]=bits 5..1. If bit 0 is 1 (consumer), pins[5:1]=bits 12..8.
- R7: Frame index 0 is the `frame_stb` that carries `blk_start`. Otherwise the index advances by one per frame strobe and wraps after BLK_FRAMES-1. The report updates only on frame strobes at indices 0, BLK_FRAMES/3 and 2*BLK_FRAMES/3, and holds at all other times.
- R8: At an update, the code is 0 unless at least 2*BLK_FRAMES/3 consecutive earlier frame strobes had `fck_ok`=1. When that holds, the code is `freq_meas`+1 for `freq_meas` <= FREQ_MAX, and 7 above it.
- R9: The three error bits of the report are sticky from one update to the next: any pulse, or any low lock, in between sets the bit at the next update, and the following update clears it.
- R10: After reset, `pins`, `err_flag` and `vflag` are all 0 for either value of `sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_stb | input | 1 | One pulse per received sample |
| par_err | input | 1 | Parity error pulse from the decoder |
| bmc_err | input | 1 | Biphase coding violation pulse |
| pll_locked | input | 1 | Receiver PLL lock indication |
| validity | input | 1 | Validity bit of the current sample |
| frame_stb | input | 1 | One pulse per frame |
| blk_start | input | 1 | Marks the frame strobe that begins a status block |
| fck_ok | input | 1 | Frequency reference seen during this frame |
| freq_meas | input | MEAS_W | Measured frequency range |
| chan_sel | input | 1 | Status channel pick: 0 left, 1 right |
| cs_left | input | CS_W | Channel-status bits, left channel |
| cs_right | input | CS_W | Channel-status bits, right channel |
| blk_bnd | input | 1 | Status block boundary; rising edge latches the status field |
| sel | input | 1 | Pin display select |
| err_flag | output | 1 | Per-sample error flag |
| vflag | output | 1 | Validity OR error |
| pins | output | 6 | Dual-function display pins |

## Verification
The bench builds the block with BLK_FRAMES=12, so the report updates land at frames 0, 4 and 8 and qualification needs 8 clean frames. A wrap of the frame index, a loss of the reference in mid-block and the exact frame at which the code first qualifies can then all be reached in a few dozen frames. FREQ_MAX keeps its default of 5, so a measurement of 9 exercises the out-of-range code. CS_W=16 places both the professional and the consumer mapping inside the inputs.

// File: rtl/rsr_pkg.sv
package rsr_pkg;
    localparam int PIN_W = 6;
    localparam logic [2:0] CODE_NONE = 3'd0;
    localparam logic [2:0] CODE_OOR  = 3'd7;

    typedef struct packed {
        logic [2:0] code;
        logic       unl;
        logic       bmc;
        logic       par;
    } rep_t;
endpackage

// File: rtl/rsr_err_track.sv
module rsr_err_track (
    input  logic clk,
    input  logic rst_n,
    input  logic sample_stb,
    input  logic par_err,
    input  logic bmc_err,
    input  logic pll_locked,
    input  logic validity,
    output logic err_flag,
    output logic vflag
);
    typedef struct packed {
        logic acc;
        logic err;
        logic val;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sample_stb) begin
            st_d.err = st_q.acc | par_err | bmc_err;
            st_d.val = validity;
            st_d.acc = 1'b0;
        end else begin
            st_d.acc = st_q.acc | par_err | bmc_err;
        end
        if (!pll_locked) st_d.err = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign err_flag = st_q.err;
    assign vflag    = st_q.err | st_q.val;

    assert_unlock_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !pll_locked |=> err_flag);
    assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (pll_locked && !sample_stb) |=> $stable(err_flag));
endmodule

// File: rtl/rsr_cs_latch.sv
module rsr_cs_latch #(
    parameter int CS_W    = 16,
    parameter int PRO_LSB = 1,
    parameter int CON_LSB = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     chan_sel,
    input  logic [CS_W-1:0]          cs_left,
    input  logic [CS_W-1:0]          cs_right,
    input  logic                     blk_bnd,
    output logic [rsr_pkg::PIN_W-1:0] cs_pins
);
    localparam int FLD_W = rsr_pkg::PIN_W - 1;

    typedef struct packed {
        logic                      bnd;
        logic [rsr_pkg::PIN_W-1:0] pins;
    } st_t;

    st_t st_d, st_q;
    logic [CS_W-1:0] pick;
    logic            edge_seen;

    always_comb begin
        pick      = chan_sel ? cs_right : cs_left;
        edge_seen = blk_bnd && !st_q.bnd;
        st_d      = st_q;
        st_d.bnd  = blk_bnd;
        if (edge_seen) begin
            if (pick[0]) st_d.pins = {pick[CON_LSB +: FLD_W], 1'b1};
            else         st_d.pins = {pick[PRO_LSB +: FLD_W], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cs_pins = st_q.pins;

    assert_cs_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_seen |=> $stable(cs_pins));
endmodule

// File: rtl/rsr_freq_report.sv
module rsr_freq_report #(
    parameter int BLK_FRAMES = 192,
    parameter int FREQ_MAX   = 5,
    parameter int MEAS_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_stb,
    input  logic              blk_start,
    input  logic              fck_ok,
    input  logic [MEAS_W-1:0] freq_meas,
    input  logic              par_err,
    input  logic              bmc_err,
    input  logic              pll_locked,
    output rsr_pkg::rep_t     rep
);
    import rsr_pkg::*;

    localparam int UPD   = BLK_FRAMES / 3;
    localparam int QUAL  = 2 * UPD;
    localparam int FRM_W = $clog2(BLK_FRAMES);
    localparam int CNT_W = $clog2(QUAL + 1);

    typedef struct packed {
        logic [FRM_W-1:0] frm;
        logic [CNT_W-1:0] cnt;
        logic             s_par;
        logic             s_bmc;
        logic             s_unl;
        rep_t             rep;
    } st_t;

    st_t st_d, st_q;
    logic [FRM_W-1:0] idx;
    logic             upd;
    logic             qual;
    logic [2:0]       code_now;

    always_comb begin
        if (blk_start)                            idx = '0;
        else if (st_q.frm == FRM_W'(BLK_FRAMES-1)) idx = '0;
        else                                      idx = st_q.frm + 1'b1;

        upd  = frame_stb && (idx == '0 || idx == FRM_W'(UPD) || idx == FRM_W'(QUAL));
        qual = (st_q.cnt >= CNT_W'(QUAL));

        if (!qual)                               code_now = CODE_NONE;
        else if (freq_meas > MEAS_W'(FREQ_MAX))  code_now = CODE_OOR;
        else                                     code_now = 3'(freq_meas) + 3'd1;

        st_d       = st_q;
        st_d.s_par = st_q.s_par | par_err;
        st_d.s_bmc = st_q.s_bmc | bmc_err;
        st_d.s_unl = st_q.s_unl | !pll_locked;

        if (frame_stb) begin
            st_d.frm = idx;
            if (!fck_ok)                        st_d.cnt = '0;
            else if (st_q.cnt != CNT_W'(QUAL))  st_d.cnt = st_q.cnt + 1'b1;
        end

        if (upd) begin
            st_d.rep.code = code_now;
            st_d.rep.unl  = st_d.s_unl;
            st_d.rep.bmc  = st_d.s_bmc;
            st_d.rep.par  = st_d.s_par;
            st_d.s_par    = 1'b0;
            st_d.s_bmc    = 1'b0;
            st_d.s_unl    = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rep = st_q.rep;

    assert_report_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(rep));
    assert_unqualified_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !qual) |=> (rep.code == CODE_NONE));
    assert_sticky_par_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && par_err) |=> rep.par);
endmodule

// File: rtl/rx_status_report.sv
module rx_status_report #(
    parameter int BLK_FRAMES = 192,
    parameter int FREQ_MAX   = 5,
    parameter int MEAS_W     = 4,
    parameter int CS_W       = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_stb,
    input  logic              par_err,
    input  logic              bmc_err,
    input  logic              pll_locked,
    input  logic              validity,
    input  logic              frame_stb,
    input  logic              blk_start,
    input  logic              fck_ok,
    input  logic [MEAS_W-1:0] freq_meas,
    input  logic              chan_sel,
    input  logic [CS_W-1:0]   cs_left,
    input  logic [CS_W-1:0]   cs_right,
    input  logic              blk_bnd,
    input  logic              sel,
    output logic              err_flag,
    output logic              vflag,
    output logic [5:0]        pins
);
    import rsr_pkg::*;

    logic [PIN_W-1:0] cs_pins;
    rep_t             rep;

    rsr_err_track u_err (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_stb (sample_stb),
        .par_err    (par_err),
        .bmc_err    (bmc_err),
        .pll_locked (pll_locked),
        .validity   (validity),
        .err_flag   (err_flag),
        .vflag      (vflag)
    );

    rsr_cs_latch #(.CS_W(CS_W), .PRO_LSB(1), .CON_LSB(8)) u_cs (
        .clk      (clk),
        .rst_n    (rst_n),
        .chan_sel (chan_sel),
        .cs_left  (cs_left),
        .cs_right (cs_right),
        .blk_bnd  (blk_bnd),
        .cs_pins  (cs_pins)
    );

    rsr_freq_report #(.BLK_FRAMES(BLK_FRAMES), .FREQ_MAX(FREQ_MAX), .MEAS_W(MEAS_W)) u_freq (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_stb  (frame_stb),
        .blk_start  (blk_start),
        .fck_ok     (fck_ok),
        .freq_meas  (freq_meas),
        .par_err    (par_err),
        .bmc_err    (bmc_err),
        .pll_locked (pll_locked),
        .rep        (rep)
    );

    always_comb pins = sel ? cs_pins : rep;

    assert_vflag_covers_err_R3: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |-> vflag);
    assert_status_view_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |-> (pins == rep));
endmodule

// File: tb/rx_status_report_test.sv
module rx_status_report_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_stb = 1'b0, par_err = 1'b0, bmc_err = 1'b0;
    logic        pll_locked = 1'b1, validity = 1'b0;
    logic        frame_stb = 1'b0, blk_start = 1'b0, fck_ok = 1'b0;
    logic [3:0]  freq_meas = 4'd0;
    logic        chan_sel = 1'b0;
    logic [15:0] cs_left = '0, cs_right = '0;
    logic        blk_bnd = 1'b0, sel = 1'b0;
    logic        err_flag, vflag;
    logic [5:0]  pins;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #4 clk = ~clk;

    rx_status_report #(.BLK_FRAMES(12), .FREQ_MAX(5), .MEAS_W(4), .CS_W(16)) uut (
        .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb), .par_err(par_err),
        .bmc_err(bmc_err), .pll_locked(pll_locked), .validity(validity),
        .frame_stb(frame_stb), .blk_start(blk_start), .fck_ok(fck_ok),
        .freq_meas(freq_meas), .chan_sel(chan_sel), .cs_left(cs_left),
        .cs_right(cs_right), .blk_bnd(blk_bnd), .sel(sel),
        .err_flag(err_flag), .vflag(vflag), .pins(pins)
    );

    // {pre_par, pre_bmc, stb_par, stb_bmc, validity, exp_err, exp_vflag}
    localparam logic [6:0] VEC [8] = '{
        7'b00000_00, 7'b10000_11, 7'b01001_11, 7'b00100_11,
        7'b00010_11, 7'b00001_01, 7'b00000_00, 7'b11001_11
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk) rst_n = 1'b1;
    endtask

    task automatic frame(input logic start, input logic fck);
        @(negedge clk) begin frame_stb = 1'b1; blk_start = start; fck_ok = fck; end
        @(negedge clk) begin frame_stb = 1'b0; blk_start = 1'b0; end
    endtask

    task automatic strobe(input logic val);
        @(negedge clk) begin sample_stb = 1'b1; validity = val; end
        @(negedge clk) sample_stb = 1'b0;
    endtask

    initial begin
        do_reset();
        // R10: reset state in both views
        chk("R10 err", err_flag, 0);
        chk("R10 vflag", vflag, 0);
        chk("R10 pins report", pins, 0);
        sel = 1'b1; #1;
        chk("R10 pins status", pins, 0);
        sel = 1'b0;

        // R1 / R3 vector table
        for (int i = 0; i < 8; i++) begin
            @(negedge clk) begin par_err = VEC[i][6]; bmc_err = VEC[i][5]; end
            @(negedge clk) begin
                par_err = VEC[i][4]; bmc_err = VEC[i][3];
                validity = VEC[i][2]; sample_stb = 1'b1;
            end
            @(negedge clk) begin par_err = 0; bmc_err = 0; sample_stb = 0; end
            chk("R1 err vector", err_flag, VEC[i][1]);
            chk("R3 vflag vector", vflag, VEC[i][0]);
        end
        // R1 hold between strobes
        @(negedge clk);
        chk("R1 hold", err_flag, 1);

        // R2 unlock without strobe
        strobe(1'b0);
        chk("R2 clean before unlock", err_flag, 0);
        @(negedge clk) pll_locked = 1'b0;
        @(negedge clk) pll_locked = 1'b1;
        chk("R2 unlock raises", err_flag, 1);
        repeat (3) @(negedge clk);
        chk("R2 held after relock", err_flag, 1);
        strobe(1'b0);
        chk("R2 cleared by clean strobe", err_flag, 0);

        // Frequency report, BLK_FRAMES=12: updates at 0,4,8, qualify at 8
        do_reset();
        sel = 1'b0; freq_meas = 4'd2;
        frame(1'b1, 1'b1);
        chk("R8 unqualified at frame 0", pins, 6'b000000);
        frame(0, 1); frame(0, 1);
        @(negedge clk) par_err = 1'b1;
        @(negedge clk) par_err = 1'b0;
        frame(0, 1);
        chk("R7 no update mid-block", pins, 6'b000000);
        frame(0, 1);
        chk("R9 parity sticky at frame 4", pins, 6'b000001);
        frame(0, 1); frame(0, 1); frame(0, 1);
        frame(0, 1);
        chk("R8 qualified code at frame 8", pins, 6'b011000);
        freq_meas = 4'd9;
        frame(0, 1);
        chk("R7 hold at frame 9", pins, 6'b011000);
        frame(0, 1); frame(0, 1);
        frame(0, 1);
        chk("R8 out of range at wrapped frame 0", pins, 6'b111000);
        frame(0, 0);
        frame(0, 1); frame(0, 1);
        frame(0, 1);
        chk("R8 reference lost gives code 0", pins, 6'b000000);
        @(negedge clk) pll_locked = 1'b0;
        @(negedge clk) pll_locked = 1'b1;
        frame(0, 1); frame(0, 1); frame(0, 1);
        frame(0, 1);
        chk("R9 unlock sticky at frame 8", pins, 6'b000100);

        // Channel status latch
        sel = 1'b1;
        cs_left = 16'h0014; cs_right = 16'h1A01; chan_sel = 1'b0;
        repeat (2) @(negedge clk);
        chk("R5 no capture without edge", pins, 6'b000000);
        @(negedge clk) blk_bnd = 1'b1;
        @(negedge clk);
        chk("R6 professional mapping", pins, 6'b010100);
        chan_sel = 1'b1;
        repeat (2) @(negedge clk);
        chk("R5 ignored while boundary high", pins, 6'b010100);
        @(negedge clk) blk_bnd = 1'b0;
        @(negedge clk) blk_bnd = 1'b1;
        @(negedge clk);
        chk("R6 consumer mapping right channel", pins, 6'b110101);
        sel = 1'b0; #1;
        chk("R4 report view", pins, 6'b000100);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule